// File: doc/BRIEF.md
# Six-Channel Shared-Period PWM with Complementary Dead-Time Pair

This block generates six pulse-width modulated outputs from one free-running up-counter. Every channel compares the shared count against its own duty value, so all channels run at the same period and start their pulses together at the top of each period. Channel 0 also has an inverted companion output. Whenever its compare result changes, the output that is about to turn on is held off for a programmable number of clock cycles, from 0 to 15. The pair can therefore drive the high and low switches of a half-bridge without shoot-through.

Software stages a new period and six new duty values and then pulses a load strobe. The block applies the staged set as a whole at the next counter wrap, so no period ever mixes old and new settings. While the block is disabled, a staged set is applied at once, which lets a configuration be loaded before the first enable. A one-cycle interrupt pulse marks every wrap. The PWM clock itself, chosen among the chip's clock sources, arrives as the block's clock input.

The configuration and strobe inputs are plain control pins. Nothing here streams, so there is no handshake and the block never applies back-pressure.

Top module: `pwm6_dt`

## Requirements
- R1: While enabled, the shared counter steps by one per clock from 0 to the active period value P and then returns to 0, so one period lasts P+1 clocks.
- R2: `period_irq` is high for exactly one clock per wrap. It appears in the clock whose outputs reflect count P, which is P+1 clocks after enable when the block starts from rest.
- R3: For channels 1 to 5, the output is high while the count is below that channel's duty value. A duty of 0 gives a constant low, and a duty above P gives a constant high (P+1 high clocks per period). Outputs are registered and lag the count by one clock.
- R4: `period` and `duty` are copied into a staging set only on a clock with `load` high. The staged set becomes active at the next wrap. Changing the inputs without `load` has no effect, and a load in mid-period leaves the rest of that period on the old values.
- R5: With `en` low, all outputs and `period_irq` are low from the next clock, the counter is held at 0, and a pending staged set is applied directly. After enable, the first output clock reflects count 0 under the new values.
- R6: When channel 0's compare result rises, `ch0_n` goes low on the next output clock, and `pwm_o[0]` rises only after `dead` further clocks. With duty d and 0<d≤P, P is high for max(0, d−dead) clocks per period.
- R7: When channel 0's compare result falls, `pwm_o[0]` goes low on the next output clock, and `ch0_n` rises only after `dead` further clocks. N is high for max(0, P+1−d−dead) clocks per period. With d=0, N stays high all period; with d>P, N stays low all period.
- R8: `pwm_o[0]` and `ch0_n` are never high in the same clock.
- R9: With `dead` = 0, `pwm_o[0]` matches a plain compare channel with the same duty, and `ch0_n` is its exact complement while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock, already selected from the available sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the counter at zero and the outputs low |
| period | input | 16 | Period value P to stage (period lasts P+1 clocks) |
| duty | input | 96 | Six 16-bit duty values, channel i in bits [16i+15:16i] |
| dead | input | 4 | Non-overlap time for channel 0, in clocks (0–15) |
| load | input | 1 | Staging strobe for `period` and `duty` |
| pwm_o | output | 6 | Channel outputs; bit 0 is the P side of the complementary pair |
| ch0_n | output | 1 | Complementary N output of channel 0 |
| period_irq | output | 1 | One-clock pulse per counter wrap |

## Verification
The bench builds the block with its default parameters: six channels, a 16-bit count and a 4-bit dead time. It then runs short periods of 8 to 20 clocks. With periods that short, the full dead-time range reaches cases where the delay swallows a whole pulse on both sides, and duties of zero, equal to P and above P all occur within a few hundred clocks. A scoreboard compares per-period high-time totals and overlap counts against values derived from the requirements. Directed probes cover mid-period loads, inputs changed without a load, and restart timing after a disable.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned DEF_NCH = 6;
  localparam int unsigned DEF_CW  = 16;
  localparam int unsigned DEF_DW  = 4;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int unsigned NCH = pwm_pkg::DEF_NCH,
  parameter int unsigned CW  = pwm_pkg::DEF_CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              wrap,
  input  logic [CW-1:0]     per_in,
  input  logic [NCH*CW-1:0] duty_in,
  output logic [CW-1:0]     per_act,
  output logic [NCH*CW-1:0] duty_act
);
  logic [CW-1:0]     stage_per;
  logic [NCH*CW-1:0] stage_duty;
  logic              pend;
  logic              apply;

  assign apply = pend && (wrap || !en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_per  <= '0;
      stage_duty <= '0;
      pend       <= 1'b0;
      per_act    <= '0;
      duty_act   <= '0;
    end else begin
      if (load) begin
        stage_per  <= per_in;
        stage_duty <= duty_in;
      end
      if (apply) begin
        per_act  <= stage_per;
        duty_act <= stage_duty;
      end
      if (load)       pend <= 1'b1;
      else if (apply) pend <= 1'b0;
    end
  end

  AST_HOLD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(per_act)); // R4
  AST_HOLD_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(duty_act)); // R4
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CW = pwm_pkg::DEF_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] per_act,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  assign wrap = en && (cnt >= per_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= per_act)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R5
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int unsigned DW = pwm_pkg::DEF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          raw,
  input  logic [DW-1:0] dead,
  output logic          p_o,
  output logic          n_o
);
  logic          r_q;
  logic [DW-1:0] dc_q;
  logic [DW-1:0] dc_n;
  logic          chg;

  assign chg = (raw != r_q);

  always_comb begin
    if (chg)              dc_n = dead;
    else if (dc_q != '0)  dc_n = dc_q - 1'b1;
    else                  dc_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q  <= 1'b0;
      dc_q <= '0;
      p_o  <= 1'b0;
      n_o  <= 1'b0;
    end else if (!en) begin
      r_q  <= 1'b0;
      dc_q <= '0;
      p_o  <= 1'b0;
      n_o  <= 1'b0;
    end else begin
      r_q  <= raw;
      dc_q <= dc_n;
      p_o  <= raw && (dc_n == '0);
      n_o  <= !raw && (dc_n == '0);
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_o && n_o)); // R8
  AST_N_OFF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    raw |=> !n_o); // R6
  AST_P_OFF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !p_o); // R7
endmodule

// File: rtl/pwm6_dt.sv
module pwm6_dt #(
  parameter int unsigned NCH = pwm_pkg::DEF_NCH,
  parameter int unsigned CW  = pwm_pkg::DEF_CW,
  parameter int unsigned DW  = pwm_pkg::DEF_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CW-1:0]     period,
  input  logic [NCH*CW-1:0] duty,
  input  logic [DW-1:0]     dead,
  input  logic              load,
  output logic [NCH-1:0]    pwm_o,
  output logic              ch0_n,
  output logic              period_irq
);
  localparam int unsigned NPLAIN = NCH - 1;

  logic [CW-1:0]     per_act;
  logic [NCH*CW-1:0] duty_act;
  logic [CW-1:0]     cnt;
  logic              wrap;
  logic [NCH-1:0]    raw;
  logic [NPLAIN:1]   plain_q;
  logic              p0;
  logic              irq_q;

  pwm_shadow #(.NCH(NCH), .CW(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .wrap(wrap),
    .per_in(period), .duty_in(duty), .per_act(per_act), .duty_act(duty_act)
  );

  pwm_timebase #(.CW(CW)) u_tbase (
    .clk(clk), .rst_n(rst_n), .en(en), .per_act(per_act),
    .cnt(cnt), .wrap(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign raw[i] = en && (cnt < duty_act[i*CW +: CW]);
  end

  pwm_deadband #(.DW(DW)) u_dband (
    .clk(clk), .rst_n(rst_n), .en(en), .raw(raw[0]), .dead(dead),
    .p_o(p0), .n_o(ch0_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      plain_q <= raw[NCH-1:1];
      irq_q   <= wrap;
    end
  end

  assign pwm_o      = {plain_q, p0};
  assign period_irq = irq_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((pwm_o == '0) && !ch0_n && !period_irq)); // R5
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq |-> (cnt == '0)); // R2
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act[CW +: CW] == '0) |=> !pwm_o[1]); // R3
endmodule

// File: tb/tb_pwm6_dt.sv
module tb_pwm6_dt;
  typedef struct {
    int len;
    int hi[6];
    int nhi;
    int ovl;
    int dt;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] period = '0;
  logic [15:0] dv[6];
  logic [95:0] duty;
  logic [3:0]  dead = '0;
  logic        load = 1'b0;
  logic [5:0]  pwm_o;
  logic        ch0_n;
  logic        period_irq;

  int nchecks = 0;
  int nfail = 0;
  int skip = 2;
  rec_t exp_q[$];
  rec_t acc;
  bit done = 1'b0;

  assign duty = {dv[5], dv[4], dv[3], dv[2], dv[1], dv[0]};

  always #2.5 clk = ~clk;

  pwm6_dt dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .duty(duty),
    .dead(dead), .load(load), .pwm_o(pwm_o), .ch0_n(ch0_n),
    .period_irq(period_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  function automatic rec_t mk_exp(input int per, input int d[6], input int dt);
    rec_t e;
    int len, d0, lo;
    len = per + 1;
    for (int i = 0; i < 6; i++) e.hi[i] = (d[i] < len) ? d[i] : len;
    d0 = e.hi[0];
    lo = len - d0;
    if (d0 == 0) begin
      e.hi[0] = 0; e.nhi = len;
    end else if (lo == 0) begin
      e.hi[0] = len; e.nhi = 0;
    end else begin
      e.hi[0] = (d0 > dt) ? d0 - dt : 0;
      e.nhi   = (lo > dt) ? lo - dt : 0;
    end
    e.len = len;
    e.ovl = 0;
    e.dt  = dt;
    return e;
  endfunction

  function automatic void clr();
    acc.len = 0; acc.nhi = 0; acc.ovl = 0; acc.dt = 0;
    for (int i = 0; i < 6; i++) acc.hi[i] = 0;
  endfunction

  // Monitor: accumulates one period, compares against the scoreboard queue
  always @(negedge clk) begin
    if (!rst_n || !en) clr();
    else begin
      acc.len++;
      for (int i = 0; i < 6; i++) if (pwm_o[i]) acc.hi[i]++;
      if (ch0_n) acc.nhi++;
      if (pwm_o[0] && ch0_n) acc.ovl++;
      if (period_irq) begin
        if (skip > 0) skip--;
        else if (exp_q.size() > 0) begin
          rec_t e;
          e = exp_q.pop_front();
          check(acc.len == e.len, "R1 period length", acc.len, e.len);
          for (int i = 1; i < 6; i++)
            check(acc.hi[i] == e.hi[i], $sformatf("R3 ch%0d high time", i), acc.hi[i], e.hi[i]);
          check(acc.hi[0] == e.hi[0], (e.dt == 0) ? "R9 ch0 P high time" : "R6 ch0 P high time",
                acc.hi[0], e.hi[0]);
          check(acc.nhi == e.nhi, (e.dt == 0) ? "R9 ch0 N high time" : "R7 ch0 N high time",
                acc.nhi, e.nhi);
          check(acc.ovl == 0, "R8 P/N overlap cycles", acc.ovl, 0);
        end
        clr();
      end
    end
  end

  task automatic setin(input int per, input int d[6], input int dt);
    period = 16'(per);
    for (int i = 0; i < 6; i++) dv[i] = 16'(d[i]);
    dead = 4'(dt);
  endtask

  task automatic pulse_load();
    load = 1'b1;
    @(negedge clk); #1;
    load = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Driver: applies a configuration and pushes expected period records
  task automatic run_cfg(input int per, input int d[6], input int dt, input int n);
    @(negedge clk); #1;
    setin(per, d, dt);
    skip = 2;
    pulse_load();
    for (int k = 0; k < n; k++) exp_q.push_back(mk_exp(per, d, dt));
    drain();
  endtask

  initial begin
    int c1[6] = '{5, 0, 20, 25, 10, 19};
    int c2[6] = '{8, 3, 1, 19, 0, 12};
    int c3[6] = '{10, 7, 2, 4, 30, 0};
    int c4[6] = '{0, 9, 9, 9, 9, 9};
    int c5[6] = '{30, 1, 18, 5, 6, 7};
    int cn[6] = '{4, 2, 12, 0, 6, 11};
    int cx[6] = '{2, 2, 2, 2, 2, 2};
    int ce[6] = '{5, 1, 0, 8, 3, 7};
    for (int i = 0; i < 6; i++) dv[i] = '0;
    repeat (3) @(negedge clk);
    check(pwm_o == 6'b0 && !ch0_n && !period_irq, "R5 outputs low in reset",
          int'({pwm_o, ch0_n, period_irq}), 0);
    #1 rst_n = 1'b1;
    // load while disabled, then start
    @(negedge clk); #1;
    setin(19, c1, 0);
    pulse_load();
    repeat (2) @(negedge clk);
    #1 en = 1'b1;
    skip = 2;
    for (int k = 0; k < 3; k++) exp_q.push_back(mk_exp(19, c1, 0));
    drain();
    run_cfg(19, c2, 3, 2);
    run_cfg(19, c3, 15, 2);
    run_cfg(19, c4, 4, 2);
    run_cfg(19, c5, 6, 2);
    run_cfg(19, c2, 3, 1);
    // R4: inputs changed without a load have no effect
    @(negedge clk); #1;
    setin(9, cx, 3);
    for (int k = 0; k < 2; k++) exp_q.push_back(mk_exp(19, c2, 3));
    drain();
    @(negedge clk); #1;
    setin(19, c2, 3);
    // R4: load in mid-period takes effect only at the next wrap
    do @(negedge clk); while (!period_irq);
    repeat (3) @(negedge clk);
    #1;
    exp_q.push_back(mk_exp(19, c2, 3));
    exp_q.push_back(mk_exp(11, cn, 3));
    exp_q.push_back(mk_exp(11, cn, 3));
    setin(11, cn, 3);
    pulse_load();
    drain();
    // R5: disable holds everything low, counter restarts from zero
    @(negedge clk); #1;
    en = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(pwm_o == 6'b0 && !ch0_n && !period_irq, "R5 outputs low while disabled",
            int'({pwm_o, ch0_n, period_irq}), 0);
    end
    #1;
    setin(7, ce, 0);
    pulse_load();
    repeat (2) @(negedge clk);
    #1;
    skip = 2;
    en = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (k == 1) check(pwm_o[1] == 1'b1, "R5 first cycle reflects count 0", int'(pwm_o[1]), 1);
      if (k == 2) check(pwm_o[1] == 1'b0, "R5 new duty applied after enable", int'(pwm_o[1]), 0);
      if (k == 8) check(period_irq == 1'b1, "R2 irq at P+1 clocks after enable", int'(period_irq), 1);
      else check(period_irq == 1'b0, "R2 irq single pulse", int'(period_irq), 0);
    end
    for (int k = 0; k < 2; k++) exp_q.push_back(mk_exp(7, ce, 0));
    drain();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog (all requirements) act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end
endmodule